// File: doc/BRIEF.md
# Standby and Reset Mode Sequencer

This block decides which low-power or reset mode a small microcontroller core is in. It also drives the enables that follow from that mode. The core can be in one of five modes:

- held in reset
- waiting for the main oscillator to settle
- running
- napping with only the CPU clock stopped (sleep)
- fully stopped with the oscillator off (stop)

Software asks for a low-power mode by writing a two-bit standby request word while it runs. Interrupts and the external reset pin bring the core back.

Leaving stop always passes through the settling wait, which is timed by a tick from a timebase counter. The block asks for that counter to be cleared so that the wait is counted in full. Leaving sleep needs no wait, because the oscillator never stopped. An external reset is honoured in every mode, the settling wait included. The software and watchdog resets act only while the core runs.

Top module: `standby_sequencer`

## Requirements
- R1: While `rst` is high, `mode` is 0 (reset), `cpu_rst` is 1, `osc_en` is 1, and `cpu_clk_en` and `per_clk_en` are 0.
- R2: In reset, the mode moves to the settling wait (1) on the first clock edge at which `ext_rst`, `sw_rst` and `wdt_rst` are all low. `tb_clr` is 1 throughout reset.
- R3: In the settling wait, `stab_tick` moves the mode to run (2). If `ext_rst` is high at the same edge, the mode goes to reset (0) instead.
- R4: In run, any of `ext_rst`, `sw_rst` or `wdt_rst` sends the mode to reset at the next edge, ahead of any pending standby request.
- R5: A write (`stby_wr` high) in run with request bit 0 (sleep) set records a request. The mode is sleep (3) after the following edge. A write made in any mode other than run has no effect.
- R6: A write in run with request bit 1 (stop) set leads to stop (4) in the same way. Stop wins when both bits are set.
- R7: In sleep, `irq` or `ext_irq` returns the mode to run at the next edge. `ext_rst` sends it to reset and takes priority.
- R8: In stop, `irq` alone has no effect. `ext_irq` moves the mode to the settling wait. `ext_rst` sends it to reset and takes priority.
- R9: The enables follow the mode:
  - Run sets the oscillator, peripheral and CPU enables.
  - Sleep sets the oscillator and peripheral enables only.
  - The settling wait sets the oscillator enable only.
  - Stop sets no enables and raises `tb_clr`.
- R10: `cpu_rst` is 1 in the settling wait only when that wait was entered from reset. After a wake from stop it is 0.
- R11: The request bits clear themselves when their mode is entered. After a return to run, the core stays in run until a new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | power-on reset, synchronous, active high |
| ext_rst | input | 1 | external reset request |
| sw_rst | input | 1 | software reset request |
| wdt_rst | input | 1 | watchdog reset request |
| stby_wr | input | 1 | write strobe for the standby request word |
| stby_req | input | 2 | request word: bit 0 sleep, bit 1 stop |
| irq | input | 1 | any enabled internal interrupt |
| ext_irq | input | 1 | external interrupt |
| stab_tick | input | 1 | timebase end-of-settling tick |
| mode | output | 3 | current mode: 0 reset, 1 wait, 2 run, 3 sleep, 4 stop |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | main oscillator enable |
| per_clk_en | output | 1 | peripheral clock enable |
| cpu_rst | output | 1 | CPU reset hold |
| tb_clr | output | 1 | timebase counter clear |

## Verification
The properties assume that every input is synchronous and sampled once per edge. They also assume that `stab_tick` can arrive in any cycle; no spacing is assumed. The stimulus drives all inputs on the falling edge and holds them for a whole cycle. It deliberately makes competing events coincide: a reset together with a tick, a reset together with a wake-up, and a write together with a reset. This reaches the priority orderings that the properties state.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int MODE_W = 3;
    localparam int REQ_W  = 2;
    localparam int REQ_SLEEP_BIT = 0;
    localparam int REQ_STOP_BIT  = 1;

    typedef enum logic [MODE_W-1:0] {
        M_RESET = 3'd0,
        M_WAIT  = 3'd1,
        M_RUN   = 3'd2,
        M_SLEEP = 3'd3,
        M_STOP  = 3'd4
    } mode_e;

    typedef struct packed {
        logic osc_en;
        logic per_en;
        logic cpu_en;
        logic cpu_rst;
        logic tb_clr;
    } ctl_t;

    function automatic ctl_t mode_ctl(mode_e m, logic cold);
        ctl_t c;
        c = '0;
        unique case (m)
            M_RESET: begin c.osc_en = 1'b1; c.cpu_rst = 1'b1; c.tb_clr = 1'b1; end
            M_WAIT:  begin c.osc_en = 1'b1; c.cpu_rst = cold; end
            M_RUN:   begin c.osc_en = 1'b1; c.per_en = 1'b1; c.cpu_en = 1'b1; end
            M_SLEEP: begin c.osc_en = 1'b1; c.per_en = 1'b1; end
            M_STOP:  begin c.tb_clr = 1'b1; end
            default: begin c.osc_en = 1'b1; c.cpu_rst = 1'b1; c.tb_clr = 1'b1; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/stby_req_latch.sv
module stby_req_latch
    import stby_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REQ_W-1:0] wdata,
    input  mode_e            mode_q,
    input  mode_e            mode_nxt,
    output logic             sleep_pend,
    output logic             stop_pend
);
    logic accept;
    logic drop;

    // writes count only while the core runs; leaving run clears both bits
    assign accept = wr && (mode_q == M_RUN);
    assign drop   = (mode_nxt != M_RUN);

    always_ff @(posedge clk) begin
        if (rst || drop) begin
            sleep_pend <= 1'b0;
            stop_pend  <= 1'b0;
        end else if (accept) begin
            sleep_pend <= sleep_pend | wdata[REQ_SLEEP_BIT];
            stop_pend  <= stop_pend  | wdata[REQ_STOP_BIT];
        end
    end
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ext_rst,
    input  logic  sw_rst,
    input  logic  wdt_rst,
    input  logic  irq,
    input  logic  ext_irq,
    input  logic  stab_tick,
    input  logic  sleep_pend,
    input  logic  stop_pend,
    output mode_e mode_q,
    output mode_e mode_nxt,
    output logic  cold_q
);
    logic any_rst;
    assign any_rst = ext_rst | sw_rst | wdt_rst;

    always_comb begin
        mode_nxt = mode_q;
        unique case (mode_q)
            M_RESET: if (!any_rst) mode_nxt = M_WAIT;
            M_WAIT: begin
                if (ext_rst)        mode_nxt = M_RESET;
                else if (stab_tick) mode_nxt = M_RUN;
            end
            M_RUN: begin
                if (any_rst)         mode_nxt = M_RESET;
                else if (stop_pend)  mode_nxt = M_STOP;
                else if (sleep_pend) mode_nxt = M_SLEEP;
            end
            M_SLEEP: begin
                if (ext_rst)            mode_nxt = M_RESET;
                else if (irq | ext_irq) mode_nxt = M_RUN;
            end
            M_STOP: begin
                if (ext_rst)      mode_nxt = M_RESET;
                else if (ext_irq) mode_nxt = M_WAIT;
            end
            default: mode_nxt = M_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_RESET;
            cold_q <= 1'b1;
        end else begin
            mode_q <= mode_nxt;
            if (mode_nxt == M_RESET)    cold_q <= 1'b1;
            else if (mode_nxt == M_RUN) cold_q <= 1'b0;
        end
    end
endmodule

// File: rtl/stby_out_decode.sv
module stby_out_decode
    import stby_pkg::*;
(
    input  mode_e              mode_q,
    input  logic               cold_q,
    output logic [MODE_W-1:0]  mode,
    output logic               cpu_clk_en,
    output logic               osc_en,
    output logic               per_clk_en,
    output logic               cpu_rst,
    output logic               tb_clr
);
    ctl_t c;
    assign c          = mode_ctl(mode_q, cold_q);
    assign mode       = mode_q;
    assign cpu_clk_en = c.cpu_en;
    assign osc_en     = c.osc_en;
    assign per_clk_en = c.per_en;
    assign cpu_rst    = c.cpu_rst;
    assign tb_clr     = c.tb_clr;
endmodule

// File: rtl/standby_sequencer.sv
module standby_sequencer
    import stby_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_rst,
    input  logic              sw_rst,
    input  logic              wdt_rst,
    input  logic              stby_wr,
    input  logic [REQ_W-1:0]  stby_req,
    input  logic              irq,
    input  logic              ext_irq,
    input  logic              stab_tick,
    output logic [MODE_W-1:0] mode,
    output logic              cpu_clk_en,
    output logic              osc_en,
    output logic              per_clk_en,
    output logic              cpu_rst,
    output logic              tb_clr
);
    mode_e mode_q, mode_nxt;
    logic  cold_q, sleep_pend, stop_pend;

    stby_req_latch u_req (
        .clk(clk), .rst(rst), .wr(stby_wr), .wdata(stby_req),
        .mode_q(mode_q), .mode_nxt(mode_nxt),
        .sleep_pend(sleep_pend), .stop_pend(stop_pend)
    );

    stby_fsm u_fsm (
        .clk(clk), .rst(rst), .ext_rst(ext_rst), .sw_rst(sw_rst),
        .wdt_rst(wdt_rst), .irq(irq), .ext_irq(ext_irq),
        .stab_tick(stab_tick), .sleep_pend(sleep_pend),
        .stop_pend(stop_pend), .mode_q(mode_q), .mode_nxt(mode_nxt),
        .cold_q(cold_q)
    );

    stby_out_decode u_dec (
        .mode_q(mode_q), .cold_q(cold_q), .mode(mode),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .per_clk_en(per_clk_en),
        .cpu_rst(cpu_rst), .tb_clr(tb_clr)
    );
endmodule

// File: rtl/stby_chk.sv
module stby_chk (
    input logic       clk,
    input logic       rst,
    input logic       ext_rst,
    input logic       sw_rst,
    input logic       wdt_rst,
    input logic       irq,
    input logic       ext_irq,
    input logic       stab_tick,
    input logic [2:0] mode,
    input logic       cpu_clk_en,
    input logic       osc_en,
    input logic       per_clk_en,
    input logic       cpu_rst
);
    // R1
    rst_mode_chk: assert property (@(posedge clk) rst |=> mode == 3'd0);
    // R3
    wait_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd1 && stab_tick && !ext_rst) |=> mode == 3'd2);
    // R3
    wait_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd1 && ext_rst) |=> mode == 3'd0);
    // R4
    run_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd2 && (ext_rst || sw_rst || wdt_rst)) |=> mode == 3'd0);
    // R7
    sleep_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd3 && !ext_rst && (irq || ext_irq)) |=> mode == 3'd2);
    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd4 && !ext_rst && !ext_irq) |=> mode == 3'd4);
    // R8
    stop_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd4 && !ext_rst && ext_irq) |=> mode == 3'd1);
    // R9
    stop_gated_chk: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd4 |-> !osc_en && !cpu_clk_en && !per_clk_en);
    // R9
    run_enables_chk: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd2 |-> cpu_clk_en && per_clk_en && osc_en && !cpu_rst);
    // R10
    warm_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd4 && !ext_rst && ext_irq) |=> !cpu_rst);
    // R9
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mode <= 3'd4);
endmodule

bind standby_sequencer stby_chk u_chk (
    .clk(clk), .rst(rst), .ext_rst(ext_rst), .sw_rst(sw_rst),
    .wdt_rst(wdt_rst), .irq(irq), .ext_irq(ext_irq), .stab_tick(stab_tick),
    .mode(mode), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
    .per_clk_en(per_clk_en), .cpu_rst(cpu_rst)
);

// File: tb/tb_standby_sequencer.sv
`timescale 1ns/1ps
module tb_standby_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_rst = 0, sw_rst = 0, wdt_rst = 0, stby_wr = 0;
    logic [1:0] stby_req = 0;
    logic irq = 0, ext_irq = 0, stab_tick = 0;
    logic [2:0] mode;
    logic cpu_clk_en, osc_en, per_clk_en, cpu_rst, tb_clr;

    int tests = 0, fails = 0, cycles = 0;
    string phase = "R1";
    bit done = 0;

    // reference state: 0 reset,1 wait,2 run,3 sleep,4 stop
    int  m_state = 0;
    bit  m_cold = 1, m_sl = 0, m_st = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    standby_sequencer dut (
        .clk(clk), .rst(rst), .ext_rst(ext_rst), .sw_rst(sw_rst),
        .wdt_rst(wdt_rst), .stby_wr(stby_wr), .stby_req(stby_req),
        .irq(irq), .ext_irq(ext_irq), .stab_tick(stab_tick),
        .mode(mode), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
        .per_clk_en(per_clk_en), .cpu_rst(cpu_rst), .tb_clr(tb_clr)
    );

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        int nx;
        bit rs;
        rs = ext_rst | sw_rst | wdt_rst;
        nx = m_state;
        if (rst) begin
            nx = 0; m_cold = 1; m_sl = 0; m_st = 0;
        end else begin
            if (m_state == 0 && !rs) nx = 1;
            if (m_state == 1) nx = ext_rst ? 0 : (stab_tick ? 2 : 1);
            if (m_state == 2) nx = rs ? 0 : (m_st ? 4 : (m_sl ? 3 : 2));
            if (m_state == 3) nx = ext_rst ? 0 : ((irq | ext_irq) ? 2 : 3);
            if (m_state == 4) nx = ext_rst ? 0 : (ext_irq ? 1 : 4);
            if (nx != 2) begin
                m_sl = 0; m_st = 0;
            end else if (m_state == 2 && stby_wr) begin
                m_sl = m_sl | stby_req[0];
                m_st = m_st | stby_req[1];
            end
            if (nx == 0) m_cold = 1;
            else if (nx == 2) m_cold = 0;
        end
        m_state = nx;
    end

    function automatic logic [4:0] ref_ctl();
        // {osc, per, cpu, cpu_rst, tb_clr}
        case (m_state)
            0: return 5'b10011;
            1: return {4'b1000, 1'b0} | (m_cold ? 5'b00010 : 5'b0);
            2: return 5'b11100;
            3: return 5'b11000;
            default: return 5'b00001;
        endcase
    endfunction

    // cycle-by-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        logic [4:0] got, exp;
        if (!done) begin
            got = {osc_en, per_clk_en, cpu_clk_en, cpu_rst, tb_clr};
            exp = ref_ctl();
            tests++;
            if (mode !== 3'(m_state) || got !== exp) begin
                fails++;
                $display("FAIL %s model: mode=%0d ctl=%b expected mode=%0d ctl=%b",
                         phase, mode, got, m_state, exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            fails++;
            done = 1;
            $display("FAIL watchdog: cycles=%0d expected <= %0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_mode(int e, string r);
        tests++;
        if (mode !== 3'(e)) begin
            fails++;
            $display("FAIL %s directed: mode=%0d expected %0d", r, mode, e);
        end
    endtask

    task automatic expect_bit(logic a, logic e, string r);
        tests++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s directed: value=%b expected %b", r, a, e);
        end
    endtask

    task automatic write_req(logic [1:0] v);
        stby_wr = 1; stby_req = v; step(1);
        stby_wr = 0; stby_req = 0;
    endtask

    task automatic pulse(ref logic s);
        s = 1; step(1); s = 0;
    endtask

    task automatic to_run();
        stab_tick = 1; step(1); stab_tick = 0;
    endtask

    initial begin
        // R1 reset state
        ext_rst = 1;
        step(3);
        expect_mode(0, "R1");
        expect_bit(cpu_rst, 1, "R1");
        expect_bit(cpu_clk_en, 0, "R1");
        rst = 0;
        // R2 stays in reset while a source is high
        phase = "R2";
        step(3);
        expect_mode(0, "R2");
        expect_bit(tb_clr, 1, "R2");
        ext_rst = 0; step(1);
        expect_mode(1, "R2");
        // R10 cold wait holds cpu reset
        expect_bit(cpu_rst, 1, "R10");
        phase = "R3";
        step(4);
        expect_mode(1, "R3");
        to_run();
        expect_mode(2, "R3");
        // R5 sleep request, writes outside run ignored
        phase = "R5";
        write_req(2'b01);
        step(1);
        expect_mode(3, "R5");
        expect_bit(per_clk_en, 1, "R9");
        expect_bit(cpu_clk_en, 0, "R9");
        write_req(2'b10);
        step(2);
        // R7 irq wakes from sleep
        phase = "R7";
        pulse(irq);
        expect_mode(2, "R7");
        // R11 no self re-entry; R5 write made in sleep had no effect
        phase = "R11";
        step(5);
        expect_mode(2, "R11");
        // R6 both bits: stop wins
        phase = "R6";
        write_req(2'b11);
        step(1);
        expect_mode(4, "R6");
        expect_bit(osc_en, 0, "R9");
        expect_bit(tb_clr, 1, "R9");
        // R8 irq ignored in stop
        phase = "R8";
        pulse(irq);
        step(2);
        expect_mode(4, "R8");
        pulse(ext_irq);
        expect_mode(1, "R8");
        expect_bit(cpu_rst, 0, "R10");
        // R3 external reset beats the tick in the wait
        phase = "R3";
        ext_rst = 1; stab_tick = 1; step(1);
        ext_rst = 0; stab_tick = 0;
        expect_mode(0, "R3");
        step(1);
        expect_mode(1, "R3");
        expect_bit(cpu_rst, 1, "R10");
        to_run();
        // R8 external reset in stop
        phase = "R8";
        write_req(2'b10);
        step(2);
        pulse(ext_rst);
        expect_mode(0, "R8");
        step(1); to_run();
        // R4 software reset, then watchdog with a pending write
        phase = "R4";
        pulse(sw_rst);
        expect_mode(0, "R4");
        step(1); to_run();
        write_req(2'b10);
        wdt_rst = 1;
        step(1);
        wdt_rst = 0;
        expect_mode(0, "R4");
        step(1); to_run();
        step(2);
        expect_mode(2, "R4");
        // R7 external interrupt and external reset from sleep
        phase = "R7";
        write_req(2'b01);
        step(2);
        pulse(ext_irq);
        expect_mode(2, "R7");
        write_req(2'b01);
        step(2);
        ext_rst = 1; irq = 1; step(1);
        ext_rst = 0; irq = 0;
        expect_mode(0, "R7");
        step(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule